// File: doc/BRIEF.md
# Bounded Call Stack Controller

This block owns the stack pointer of a small 8-bit core and turns single-cycle push and pop requests into accesses on a port toward a shared 256-byte byte-addressed memory. The stack occupies a fixed window of 22 bytes at the very top of the address space (0xEA up to 0xFF) and grows downward. Register saves and restores use the same request interface as subroutine linkage. For a call, the core pushes the address of the instruction that follows the call. For a return, it pops one byte and loads that byte into its program counter.

The pointer never wraps. A push into a full window, a pop from an empty window, or a push and a pop in the same cycle each record a distinct error code. That code holds until reset and drives a halt output. From then on the block makes no memory access and keeps its pointer frozen. The memory is expected to read synchronously: the byte for a pop comes back on the cycle after the read strobe, and the block marks it valid on that cycle.

Top module: `bounded_call_stack`

## Requirements
- R1: After reset, stkPtr is 0xFF, errCode is 0, halted is 0, and memWe, memRe and popValid are all 0.
- R2: An accepted push asserts memWe for that same cycle, with memAddr equal to the current stkPtr and memWdata equal to pushData. stkPtr is one lower on the next cycle.
- R3: An accepted pop asserts memRe for that same cycle, with memAddr equal to stkPtr plus one. stkPtr is one higher on the next cycle. On that next cycle popValid is 1 and popData carries memRdata.
- R4: Every stack access targets an address from 0xEA to 0xFF. Exactly 22 pushes are accepted from empty, and stkPtr stays between 0xE9 (full) and 0xFF (empty).
- R5: A push while stkPtr is 0xE9 makes no write and leaves stkPtr unchanged. It sets errCode to 1 (overflow) and halted to 1.
- R6: A pop while stkPtr is 0xFF makes no read and leaves stkPtr unchanged. It sets errCode to 2 (underflow) and halted to 1.
- R7: Push and pop asserted in the same cycle make no memory access and leave stkPtr unchanged. They set errCode to 3 (request clash) and halted to 1.
- R8: Once errCode is nonzero, it holds its value and all requests are ignored: no memWe, no memRe, stkPtr stable. This lasts until reset, which clears the error.
- R9: Bytes come back in last-in first-out order, so a return address pushed before data bytes is returned after them with its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Single-cycle push strobe |
| popReq | input | 1 | Single-cycle pop strobe |
| pushData | input | 8 | Byte to push (register value or return address) |
| popData | output | 8 | Popped byte, valid with popValid |
| popValid | output | 1 | Popped byte present, one cycle after the pop |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memAddr | output | 8 | Memory address for the current access |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, one cycle after memRe |
| stkPtr | output | 8 | Current stack pointer |
| errCode | output | 2 | 0 none, 1 overflow, 2 underflow, 3 clash |
| halted | output | 1 | High while an error is latched |

## Verification
The stack is first exercised with short balanced sequences of distinct bytes, which separate correct last-in first-out ordering from any address offset error. A call-style pattern pushes a return address under data bytes, showing that linkage bytes survive nested traffic. A full fill of 22 bytes followed by one extra push, and a pop on an empty stack, locate the full and empty boundaries exactly and show that the three error causes give different codes. Requests issued after an error, followed by a reset, show that the error is sticky and that reset clears it.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_OVER  = 2'd1,
    ERR_UNDER = 2'd2,
    ERR_CLASH = 2'd3
  } stkErr_t;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic    doPush;
    logic    doPop;
    logic    raise;
    stkErr_t code;
  } stkStrobe_t;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       pushReq,
  input  logic       popReq,
  input  logic       isFull,
  input  logic       isEmpty,
  input  logic       isHalted,
  output stkStrobe_t strb
);

  // Decide per cycle whether a request is carried out or raises an error
  always_comb begin
    strb = '0;
    if (!isHalted) begin
      if (pushReq && popReq) begin
        strb.raise = 1'b1;
        strb.code  = ERR_CLASH;
      end else if (pushReq) begin
        if (isFull) begin
          strb.raise = 1'b1;
          strb.code  = ERR_OVER;
        end else begin
          strb.doPush = 1'b1;
        end
      end else if (popReq) begin
        if (isEmpty) begin
          strb.raise = 1'b1;
          strb.code  = ERR_UNDER;
        end else begin
          strb.doPop = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int STK_TOP   = 255,
  parameter int STK_DEPTH = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stkStrobe_t        strb,
  input  logic [DATA_W-1:0] pushData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic [ADDR_W-1:0] stkPtr,
  output logic [1:0]        errCode,
  output logic              isFull,
  output logic              isEmpty,
  output logic              isHalted
);

  localparam int STK_BASE = STK_TOP - STK_DEPTH + 1;
  localparam logic [ADDR_W-1:0] TOP_PTR  = ADDR_W'(STK_TOP);
  localparam logic [ADDR_W-1:0] FULL_PTR = ADDR_W'(STK_BASE - 1);

  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] spInc;
  stkErr_t           errReg;
  logic              rdPend;

  assign spInc = sp + ADDR_W'(1);

  // Pointer: push writes then decrements, pop increments then reads
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= TOP_PTR;
    end else if (strb.doPush) begin
      sp <= sp - ADDR_W'(1);
    end else if (strb.doPop) begin
      sp <= spInc;
    end
  end

  // Sticky error: only the first cause is kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errReg <= ERR_NONE;
    end else if (strb.raise && errReg == ERR_NONE) begin
      errReg <= strb.code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdPend <= 1'b0;
    else        rdPend <= strb.doPop;
  end

  assign memWe    = strb.doPush;
  assign memRe    = strb.doPop;
  assign memAddr  = strb.doPop ? spInc : sp;
  assign memWdata = pushData;
  assign popData  = memRdata;
  assign popValid = rdPend;
  assign stkPtr   = sp;
  assign errCode  = errReg;
  assign isFull   = (sp == FULL_PTR);
  assign isEmpty  = (sp == TOP_PTR);
  assign isHalted = (errReg != ERR_NONE);

  p_ptr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp >= FULL_PTR) && (sp <= TOP_PTR));

  p_access_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe || memRe) |-> (memAddr > FULL_PTR));

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doPush |=> (sp == $past(sp) - ADDR_W'(1)));

  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doPop |=> (popValid && sp == $past(sp) + ADDR_W'(1)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    isFull |-> !memWe);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    isEmpty |-> !memRe);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isHalted |=> (errCode == $past(errCode)));

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isHalted |-> (!memWe && !memRe && $stable(sp)));

endmodule

// File: rtl/bounded_call_stack.sv
module bounded_call_stack
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int STK_TOP   = 255,
  parameter int STK_DEPTH = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] stkPtr,
  output logic [1:0]        errCode,
  output logic              halted
);

  stkStrobe_t strb;
  logic       isFull;
  logic       isEmpty;
  logic       isHalted;

  stk_ctrl u_ctrl (
    .pushReq  (pushReq),
    .popReq   (popReq),
    .isFull   (isFull),
    .isEmpty  (isEmpty),
    .isHalted (isHalted),
    .strb     (strb)
  );

  stk_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STK_TOP   (STK_TOP),
    .STK_DEPTH (STK_DEPTH)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .pushData (pushData),
    .memRdata (memRdata),
    .memWe    (memWe),
    .memRe    (memRe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .popData  (popData),
    .popValid (popValid),
    .stkPtr   (stkPtr),
    .errCode  (errCode),
    .isFull   (isFull),
    .isEmpty  (isEmpty),
    .isHalted (isHalted)
  );

  assign halted = isHalted;

endmodule

// File: tb/tb_bounded_call_stack.sv
module tb_bounded_call_stack;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pushReq, popReq;
  logic [7:0] pushData, popData, memAddr, memWdata, memRdata, stkPtr;
  logic       popValid, memWe, memRe, halted;
  logic [1:0] errCode;

  int total = 0;
  int bad   = 0;

  logic [7:0] mem [256];
  logic [7:0] rdReg;

  logic [7:0] expSp;
  logic [1:0] expErr;
  logic [7:0] model[$];
  logic [7:0] sb[$];
  string      sbTag[$];

  always #4 clk = ~clk;

  bounded_call_stack dut (
    .clk(clk), .rst_n(rst_n), .pushReq(pushReq), .popReq(popReq),
    .pushData(pushData), .popData(popData), .popValid(popValid),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .stkPtr(stkPtr), .errCode(errCode), .halted(halted)
  );

  // Synchronous memory model
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) rdReg <= mem[memAddr];
  end
  assign memRdata = rdReg;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare popped bytes against the scoreboard
  always @(negedge clk) begin
    if (rst_n && popValid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3", "unexpected popValid", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = sb.pop_front();
        t = sbTag.pop_front();
        chk(popData == e, t, "popData", popData, e);
      end
    end
  end

  task automatic doReset();
    rst_n = 1'b0; pushReq = 1'b0; popReq = 1'b0; pushData = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    expSp = 8'hFF; expErr = 2'd0;
    model.delete(); sb.delete(); sbTag.delete();
    #1;
    chk(stkPtr == 8'hFF, "R1", "reset stkPtr", stkPtr, 8'hFF);
    chk(errCode == 2'd0 && !halted, "R1", "reset err", errCode, 0);
    chk(!memWe && !memRe && !popValid, "R1", "reset idle", {memWe, memRe, popValid}, 0);
  endtask

  // Driver: issues one request and predicts its effect
  task automatic req(input bit ps, input bit pp, input logic [7:0] d, input string tag);
    @(negedge clk);
    pushReq = ps; popReq = pp; pushData = d;
    #1;
    if (expErr != 2'd0) begin
      chk(!memWe && !memRe, tag, "access while halted", {memWe, memRe}, 0);
    end else if (ps && pp) begin
      chk(!memWe && !memRe, tag, "access on clash", {memWe, memRe}, 0);
      expErr = 2'd3;
    end else if (ps) begin
      if (expSp == 8'hE9) begin
        chk(!memWe, tag, "write when full", memWe, 0);
        expErr = 2'd1;
      end else begin
        chk(memWe && memAddr == expSp && memWdata == d, tag, "push addr", memAddr, expSp);
        chk(memAddr >= 8'hEA, "R4", "push window", memAddr, expSp);
        model.push_back(d);
        expSp = expSp - 8'd1;
      end
    end else if (pp) begin
      if (expSp == 8'hFF) begin
        chk(!memRe, tag, "read when empty", memRe, 0);
        expErr = 2'd2;
      end else begin
        chk(memRe && memAddr == expSp + 8'd1, tag, "pop addr", memAddr, expSp + 8'd1);
        sb.push_back(model.pop_back());
        sbTag.push_back(tag);
        expSp = expSp + 8'd1;
      end
    end
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
    #1;
    chk(stkPtr == expSp, tag, "stkPtr", stkPtr, expSp);
    chk(errCode == expErr, tag, "errCode", errCode, expErr);
    chk(halted == (expErr != 2'd0), tag, "halted", halted, expErr != 2'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    doReset();

    // R2 R3 R9: short balanced sequence
    req(1, 0, 8'hA1, "R2");
    req(1, 0, 8'hB2, "R2");
    req(1, 0, 8'hC3, "R2");
    req(0, 1, 8'h00, "R9");
    req(0, 1, 8'h00, "R9");
    req(0, 1, 8'h00, "R3");

    // R9: return address under data bytes
    req(1, 0, 8'h42, "R9");
    req(1, 0, 8'h11, "R2");
    req(1, 0, 8'h22, "R2");
    req(0, 1, 8'h00, "R3");
    req(0, 1, 8'h00, "R3");
    req(0, 1, 8'h00, "R9");

    // R4 R5: fill all 22 slots then overflow
    for (int i = 0; i < 22; i++) req(1, 0, 8'(8'h30 + i), "R4");
    chk(stkPtr == 8'hE9 && errCode == 2'd0, "R4", "full after 22", stkPtr, 8'hE9);
    req(1, 0, 8'h99, "R5");
    // R8: ignored afterwards
    req(0, 1, 8'h00, "R8");
    req(1, 0, 8'h55, "R8");
    req(1, 1, 8'h55, "R8");
    chk(errCode == 2'd1, "R8", "sticky overflow", errCode, 1);

    // R1 R8: reset clears, then R6 underflow
    doReset();
    req(0, 1, 8'h00, "R6");
    req(1, 0, 8'h77, "R8");
    chk(errCode == 2'd2, "R8", "sticky underflow", errCode, 2);

    // R7: clash
    doReset();
    req(1, 0, 8'h5A, "R2");
    req(1, 1, 8'h66, "R7");
    req(0, 1, 8'h00, "R8");

    // R4 R6: full drain then underflow
    doReset();
    for (int i = 0; i < 22; i++) req(1, 0, 8'(8'hC0 ^ i), "R4");
    for (int i = 0; i < 22; i++) req(0, 1, 8'h00, "R4");
    req(0, 1, 8'h00, "R6");

    @(negedge clk);
    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule